// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a timer. It sits beside a shared free-running counter and watches the counter's value bus and its count-enable strobe. The channel has two modes. In capture mode it synchronizes an external pin, detects the edge that software selected, and stores the counter value at that moment in its channel value register. In compare mode it drives an output pin. When the counter reaches the channel value, the pin is set, cleared or toggled.

Both modes raise a sticky channel flag, and that flag can drive an interrupt request. In capture mode the channel can also ask the counter owner to reload its initial value at each capture. The next captured value is then the period of the input, with no subtraction needed. Software reaches the channel through two write strobes, one for the value register and one for the configuration word, and through a flag-clear strobe. The value register is readable at all times.

Top module: `cc_timer_chan`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: chan_val = 0, pin_out = 0, chan_flag = 0, irq = 0, cnt_reset_req = 0. The configuration word reads as all zeros, which selects capture mode with no edge enabled.
- R2: The configuration word has these fields: bit 0 selects the mode (0 capture, 1 compare), bits 2:1 select the edge (00 none, 01 rising, 10 falling, 11 both), bits 4:3 select the compare action (00 none, 01 set, 10 clear, 11 toggle), bit 5 enables the interrupt, and bit 6 enables reset-on-capture. A cfg_we write takes effect at the next clock edge. In capture mode, pin_in passes through a two-flop synchronizer. The selected edge causes a capture on the second clock edge after the edge that first samples the new pin level. At that capture edge, chan_val takes the value that cnt_val has on that edge.
- R3: In capture mode, val_we writes are ignored and chan_val keeps its value. In compare mode, a val_we write loads val_wdata at the next edge.
- R4: When reset-on-capture is enabled, cnt_reset_req is high for exactly the one cycle that follows each capture edge. It is low at all other times.
- R5: In compare mode, a match is a cycle in which cnt_en is 1 and cnt_val equals chan_val. At the edge that ends a match cycle, pin_out is set, cleared, toggled or left unchanged, according to the action field.
- R6: A configuration write never changes pin_out by itself. In toggle mode, pin_out keeps its prior level until the first match. In capture mode, pin_out holds its level.
- R7: chan_flag becomes 1 at the edge that ends a capture or a match cycle. A flag_clr pulse clears chan_flag. If an event and a clear happen in the same cycle, the flag is set.
- R8: irq is 1 exactly when chan_flag is 1 and the interrupt enable bit is 1.
- R9: A cycle in which cnt_en is 0 is never a match, even when cnt_val equals chan_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_en | input | 1 | Counter count-enable strobe |
| val_we | input | 1 | Write strobe for the channel value |
| val_wdata | input | CNT_W | Channel value write data |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 7 | Configuration word |
| flag_clr | input | 1 | Clears the channel flag |
| pin_in | input | 1 | Capture input pin, asynchronous |
| pin_out | output | 1 | Compare output pin |
| chan_val | output | CNT_W | Channel value register |
| chan_flag | output | 1 | Sticky channel event flag |
| irq | output | 1 | Interrupt request |
| cnt_reset_req | output | 1 | Request to reload the counter with its initial value |

## Verification
The bench builds the channel with the default 16-bit counter width and two synchronizer stages. A behavioural model that keeps a history queue of the sampled pin predicts every output on every clock. With these values the model's three-edge capture latency exercises every edge-select code, and the bench can reload its own counter from the reset request to measure periods. Compare runs place matches in the same cycle as flag clears and in cycles where the count is stalled. They also place a value write in the same cycle as a match.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int CFG_W = 7;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic      reset_on_cap;
        logic      irq_en;
        cmp_act_e  act;
        edge_sel_e edge_sel;
        logic      cmp_mode;
    } chan_cfg_t;

    function automatic logic apply_act(input cmp_act_e a, input logic cur);
        case (a)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_TGL:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic edge_hit(input edge_sel_e s, input logic cur, input logic prev);
        case (s)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_BOTH: return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge
    import cct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_in,
    input  edge_sel_e edge_sel,
    output logic      edge_evt
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], pin_in};
    end

    assign edge_evt = edge_hit(edge_sel, chain[LAST-1], chain[LAST]);

endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  cmp_act_e         act,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] ref_val,
    output logic             match,
    output logic             pin_out
);
    assign match = active & cnt_en & (cnt_val == ref_val);

    always_ff @(posedge clk) begin
        if (rst)        pin_out <= 1'b0;
        else if (match) pin_out <= apply_act(act, pin_out);
    end

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(pin_out));

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (match && act == ACT_TGL) |=> (pin_out != $past(pin_out)));

endmodule

// File: rtl/cct_flag.sv
module cct_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_evt) |=> !flag);

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
    import cct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_en,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             cfg_we,
    input  logic [6:0]       cfg_wdata,
    input  logic             flag_clr,
    input  logic             pin_in,
    output logic             pin_out,
    output logic [CNT_W-1:0] chan_val,
    output logic             chan_flag,
    output logic             irq,
    output logic             cnt_reset_req
);
    chan_cfg_t cfg;
    logic      edge_evt;
    logic      cap_evt;
    logic      match;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg           <= '0;
            chan_val      <= '0;
            cnt_reset_req <= 1'b0;
        end else begin
            if (cfg_we) cfg <= chan_cfg_t'(cfg_wdata);
            if (cap_evt)                    chan_val <= cnt_val;
            else if (val_we && cfg.cmp_mode) chan_val <= val_wdata;
            cnt_reset_req <= cap_evt & cfg.reset_on_cap;
        end
    end

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .edge_sel (cfg.edge_sel),
        .edge_evt (edge_evt)
    );

    assign cap_evt = edge_evt & ~cfg.cmp_mode;

    cct_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .active  (cfg.cmp_mode),
        .act     (cfg.act),
        .cnt_val (cnt_val),
        .cnt_en  (cnt_en),
        .ref_val (chan_val),
        .match   (match),
        .pin_out (pin_out)
    );

    cct_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (cap_evt | match),
        .clr     (flag_clr),
        .flag    (chan_flag)
    );

    assign irq = chan_flag & cfg.irq_en;

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (chan_val == $past(cnt_val)));

    p_wr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (val_we && !cfg.cmp_mode && !cap_evt) |=> $stable(chan_val));

    p_req_value_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_reset_req |-> (chan_val == $past(cnt_val)));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(chan_flag) || $past(cfg_we)));

    p_cfg_no_pin_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !match) |=> $stable(pin_out));

endmodule

// File: tb/cc_timer_chan_tb.sv
module cc_timer_chan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam logic [W-1:0] CNT_INIT = 16'd5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_en = 1'b0;
    logic         val_we = 1'b0;
    logic [W-1:0] val_wdata = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         pin_in = 1'b0;
    logic         pin_out, chan_flag, irq, cnt_reset_req;
    logic [W-1:0] chan_val;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_timer_chan u_dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_en(cnt_en),
        .val_we(val_we), .val_wdata(val_wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .pin_in(pin_in),
        .pin_out(pin_out), .chan_val(chan_val), .chan_flag(chan_flag),
        .irq(irq), .cnt_reset_req(cnt_reset_req)
    );

    // behavioural reference model
    bit        hist[$];
    bit [6:0]  m_cfg;
    bit [W-1:0] m_val;
    bit        m_pin, m_flag, m_req;

    initial begin
        hist = {1'b0, 1'b0, 1'b0};
    end

    always @(posedge clk) begin
        bit ev, now_lvl, old_lvl, rq;
        ev = 1'b0;
        rq = 1'b0;
        if (rst) begin
            m_cfg = '0; m_val = '0; m_pin = 1'b0; m_flag = 1'b0; m_req = 1'b0;
            hist = {1'b0, 1'b0, 1'b0};
        end else begin
            now_lvl = hist[hist.size()-2];
            old_lvl = hist[hist.size()-3];
            if (m_cfg[0] == 1'b0) begin
                if ((m_cfg[1] && now_lvl && !old_lvl) || (m_cfg[2] && !now_lvl && old_lvl)) begin
                    m_val = cnt_val;
                    ev = 1'b1;
                    rq = m_cfg[6];
                end
            end else begin
                if (cnt_en && cnt_val == m_val) begin
                    ev = 1'b1;
                    case (m_cfg[4:3])
                        2'b01: m_pin = 1'b1;
                        2'b10: m_pin = 1'b0;
                        2'b11: m_pin = !m_pin;
                        default: ;
                    endcase
                end
                if (val_we) m_val = val_wdata;
            end
            if (ev) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_req = rq;
            if (cfg_we) m_cfg = cfg_wdata;
            hist.push_back(pin_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            chk("R1", "chan_val", 32'(chan_val), 32'(m_val));
            chk("R1", "pin_out", 32'(pin_out), 32'(m_pin));
            chk("R1", "chan_flag", 32'(chan_flag), 32'(m_flag));
            chk("R1", "irq", 32'(irq), 32'(m_flag & m_cfg[5]));
            chk("R1", "cnt_reset_req", 32'(cnt_reset_req), 32'(m_req));
        end else begin
            chk("R2 R3", "chan_val", 32'(chan_val), 32'(m_val));
            chk("R5 R6 R9", "pin_out", 32'(pin_out), 32'(m_pin));
            chk("R7", "chan_flag", 32'(chan_flag), 32'(m_flag));
            chk("R8", "irq", 32'(irq), 32'(m_flag & m_cfg[5]));
            chk("R4", "cnt_reset_req", 32'(cnt_reset_req), 32'(m_req));
        end
        if (cnt_reset_req) cnt_val = CNT_INIT;
        else if (cnt_en) cnt_val = cnt_val + 1'b1;
        val_we = 1'b0; cfg_we = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_cfg(input logic [6:0] c);
        cfg_we = 1'b1; cfg_wdata = c; tick();
    endtask

    task automatic pulse_pin(input int hi, input int lo);
        pin_in = 1'b1; run(hi);
        pin_in = 1'b0; run(lo);
    endtask

    task automatic write_val(input logic [W-1:0] v);
        val_we = 1'b1; val_wdata = v; tick();
    endtask

    initial begin
        @(negedge clk);
        run(3);
        rst = 1'b0;
        tick();                          // R1 post-reset state
        cnt_en = 1'b1;
        // R2 rising capture, irq enabled
        set_cfg(7'b0100010);
        pulse_pin(5, 6);
        write_val(16'hBEEF);             // R3 ignored in capture mode
        run(2);
        flag_clr = 1'b1; tick();
        // R2 falling, both, none
        set_cfg(7'b0100100);
        pulse_pin(4, 5);
        set_cfg(7'b0100110);
        pulse_pin(3, 4);
        pin_in = 1'b1; val_we = 1'b1; val_wdata = 16'h1234; tick();  // R3
        run(4);
        set_cfg(7'b0000000);             // edge none, irq off
        pin_in = 1'b0; run(5);
        pulse_pin(3, 4);
        // R4 reset on capture, period measurement
        set_cfg(7'b1000010);
        pulse_pin(2, 7);
        pulse_pin(4, 5);
        pulse_pin(6, 3);
        // R5 compare set
        set_cfg(7'b0101001);
        flag_clr = 1'b1; tick();
        write_val(cnt_val + 16'd4);
        run(8);
        // R5 clear, with R7 clear colliding with the match
        set_cfg(7'b0110001);
        write_val(cnt_val + 16'd3);
        for (int i = 0; i < 8; i++) begin
            flag_clr = (cnt_val == chan_val);
            tick();
        end
        // R6 toggle keeps level until first match; R9 stall at match value
        set_cfg(7'b0101001);
        write_val(cnt_val + 16'd2);
        run(4);
        set_cfg(7'b0111001);
        run(3);
        write_val(cnt_val + 16'd3);
        run(2);
        cnt_en = 1'b0; run(4);           // R9 counter stalled on match value
        cnt_en = 1'b1; run(3);
        write_val(cnt_val + 16'd2);
        run(5);
        // R3 value write in the same cycle as a match
        write_val(cnt_val + 16'd1);
        val_we = 1'b1; val_wdata = cnt_val + 16'd3; tick();
        run(6);
        // R6 mode change to capture holds pin
        set_cfg(7'b0011000);
        run(6);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule